// File: doc/BRIEF.md
# Common-Stop Hit Window Capture

This block records the recent hit history of one timing channel and, when a common-stop trigger arrives, collects the hits that came shortly before it. A free-running coarse counter timestamps the hits. Each coarse cycle owns one slot of a circular history of 2^SLOT_W slots, and every cycle the current slot is rewritten with either a hit and its fine value or an empty marker. A slot therefore never holds anything older than one full lap of the counter.

An accepted trigger freezes the trigger time and the requested window length. The block then walks the window's slots from oldest to newest, one slot per cycle, and copies up to MAX_HITS hits into a small channel buffer. Each copied hit is tagged with its distance in coarse cycles before the trigger. New hits keep being written into the history while the walk runs. The block then holds the event until a second-level decision arrives. A clear drops the event. An accept makes the entries readable through a valid/ready port, and the block goes idle after the last entry is read. Further triggers are ignored the whole time the block is busy.

Top module: `hit_window_capture`

## Requirements
- R1: After reset, `busy`, `done` and `rd_valid` are 0 and `hit_count` is 0.
- R2: A `trig` pulse seen while idle starts an event. The window length is W = min(`win_len`, WIN_MAX), with WIN_MAX = 1000 by default. A hit recorded on the same clock edge as the trigger has age 0. The event keeps every hit whose age is below W, and no hit from before reset.
- R3: Entries are read oldest hit first. `rd_data` is {age[SLOT_W-1:0], fine[FINE_W-1:0]}, with the age in the upper bits. The age is the trigger time minus the hit time, modulo 2^SLOT_W.
- R4: At most MAX_HITS (16) hits are kept per event. The oldest hits are kept and later ones are dropped. `hit_count` never exceeds MAX_HITS.
- R5: `busy` rises on the edge that accepts the trigger. `done` rises W+1 clock edges after that edge. A `trig` pulse while `busy` is 1 has no effect.
- R6: `l2_accept` while `done` is 1 and no readout has begun starts the readout. `rd_valid` then stays 1 until every entry is taken with `rd_ready`. `busy` falls on the edge that takes the last entry. If the event is empty, `busy` falls on the accepting edge.
- R7: `l2_clear` while the event is held drops it: `busy`, `done` and `hit_count` go to 0 on that edge. If `l2_clear` and `l2_accept` arrive together, the clear wins.
- R8: `l2_accept` and `l2_clear` have no effect while the window is being walked or while the block is idle.
- R9: Hits that arrive while an event is being walked or held are still recorded, and a later trigger can capture them.
- R10: Ages are correct when the window crosses the counter's wrap point. Slots never written since reset count as empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Coarse clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_valid | input | 1 | A hit occurred in this coarse cycle |
| hit_fine | input | FINE_W | Fine time of the hit |
| trig | input | 1 | Common-stop trigger pulse |
| win_len | input | SLOT_W | Requested window length in coarse cycles |
| l2_accept | input | 1 | Second-level accept: release the held event |
| l2_clear | input | 1 | Second-level clear: discard the held event |
| rd_ready | input | 1 | Consumer takes the current entry |
| busy | output | 1 | Event in progress, triggers ignored |
| done | output | 1 | Window walk finished, event held or being read |
| hit_count | output | $clog2(MAX_HITS+1) | Number of hits gathered |
| rd_valid | output | 1 | An entry is presented on `rd_data` |
| rd_data | output | SLOT_W+FINE_W | Age before trigger and fine time |

## Verification
A wrong write slot or read address shows up as a wrong age or fine value in `rd_data`, at the first entry of the next read out event. A wrong window count moves the rise of `done`, and the model compares `busy` and `done` every cycle, so the error is seen within one cycle. A broken cap or a stale-slot mistake changes `hit_count` as soon as the event is held. The dense-hit, wrap-around and early-after-reset events are built to expose exactly these faults.

// File: rtl/hwc_pkg.sv
package hwc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SCAN = 2'd1,
      ST_HOLD = 2'd2,
      ST_SEND = 2'd3
   } hwc_state_e;

endpackage

// File: rtl/hwc_ring_mem.sv
// Time-indexed history: one slot per coarse cycle, rewritten every cycle.
module hwc_ring_mem #(
   parameter int SLOT_W = 11,
   parameter int FINE_W = 8
) (
   input  logic              clk,
   input  logic              wr_hit,
   input  logic [FINE_W-1:0] wr_fine,
   input  logic [SLOT_W-1:0] wr_addr,
   input  logic [SLOT_W-1:0] rd_addr,
   output logic              rd_hit,
   output logic [FINE_W-1:0] rd_fine
);
   localparam int SLOTS = 1 << SLOT_W;

   logic [FINE_W:0] slot_q [SLOTS];

   always_ff @(posedge clk) begin
      slot_q[wr_addr]   <= {wr_hit, wr_fine};
      {rd_hit, rd_fine} <= slot_q[rd_addr];
   end
endmodule

// File: rtl/hwc_win_scan.sv
// Walks the frozen window oldest slot first; one read issued per cycle.
module hwc_win_scan #(
   parameter int SLOT_W  = 11,
   parameter int FINE_W  = 8,
   parameter int WIN_MAX = 1000,
   localparam int ENT_W  = SLOT_W + FINE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [SLOT_W-1:0] t_now,
   input  logic [SLOT_W-1:0] win_req,
   input  logic [SLOT_W:0]   elapsed,
   input  logic              rd_hit,
   input  logic [FINE_W-1:0] rd_fine,
   output logic [SLOT_W-1:0] rd_addr,
   output logic              active,
   output logic              fin,
   output logic              push,
   output logic [ENT_W-1:0]  push_data
);
   localparam logic [SLOT_W-1:0] WCAP = SLOT_W'(WIN_MAX);

   logic [SLOT_W-1:0] tcap_q, rem_q, pk_q, wcap_q;
   logic [SLOT_W:0]   ecap_q;
   logic              pv_q;
   logic [SLOT_W-1:0] k_age, w_eff;

   assign w_eff     = (win_req > WCAP) ? WCAP : win_req;
   assign k_age     = rem_q - SLOT_W'(1);
   assign rd_addr   = tcap_q - k_age;
   assign fin       = active && (rem_q == '0);
   assign push      = pv_q && rd_hit;
   assign push_data = {pk_q, rd_fine};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         pv_q   <= 1'b0;
         rem_q  <= '0;
         tcap_q <= '0;
         pk_q   <= '0;
         wcap_q <= '0;
         ecap_q <= '0;
      end else if (start && !active) begin
         active <= 1'b1;
         pv_q   <= 1'b0;
         tcap_q <= t_now;
         rem_q  <= w_eff;
         wcap_q <= w_eff;
         ecap_q <= elapsed;
      end else if (active) begin
         if (rem_q != '0) begin
            pv_q  <= ({1'b0, k_age} <= ecap_q);
            pk_q  <= k_age;
            rem_q <= k_age;
         end else begin
            pv_q   <= 1'b0;
            active <= 1'b0;
         end
      end
   end

   // R5: no new walk may be requested while one is running
   a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> !start);
   // R3: every gathered age lies inside the frozen window
   a_r3_age_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (pk_q < wcap_q));
endmodule

// File: rtl/hwc_chan_buf.sv
// Per-event channel buffer with hit cap and in-order readout.
module hwc_chan_buf #(
   parameter int ENT_W    = 19,
   parameter int MAX_HITS = 16,
   localparam int CNT_W   = $clog2(MAX_HITS + 1),
   localparam int IDX_W   = $clog2(MAX_HITS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [ENT_W-1:0] push_data,
   input  logic             rd_en,
   input  logic             rd_ready,
   output logic [CNT_W-1:0] count,
   output logic             rd_valid,
   output logic [ENT_W-1:0] rd_data,
   output logic             last_pop
);
   logic [ENT_W-1:0] ent_q [MAX_HITS];
   logic [CNT_W-1:0] rd_ptr_q;
   logic             room, pop;

   assign room     = count < CNT_W'(MAX_HITS);
   assign rd_valid = rd_en && (rd_ptr_q < count);
   assign rd_data  = ent_q[rd_ptr_q[IDX_W-1:0]];
   assign pop      = rd_valid && rd_ready;
   assign last_pop = pop && ((rd_ptr_q + CNT_W'(1)) == count);

   always_ff @(posedge clk) begin
      for (int i = 0; i < MAX_HITS; i++) begin
         if (push && room && (count == CNT_W'(i))) ent_q[i] <= push_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         count    <= '0;
         rd_ptr_q <= '0;
      end else begin
         if (push && room) count <= count + CNT_W'(1);
         if (pop) rd_ptr_q <= rd_ptr_q + CNT_W'(1);
      end
   end

   a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(MAX_HITS));
   a_r6_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ptr_q <= count);
endmodule

// File: rtl/hit_window_capture.sv
module hit_window_capture
   import hwc_pkg::*;
#(
   parameter int SLOT_W   = 11,
   parameter int FINE_W   = 8,
   parameter int MAX_HITS = 16,
   parameter int WIN_MAX  = 1000,
   localparam int CNT_W   = $clog2(MAX_HITS + 1),
   localparam int ENT_W   = SLOT_W + FINE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit_valid,
   input  logic [FINE_W-1:0] hit_fine,
   input  logic              trig,
   input  logic [SLOT_W-1:0] win_len,
   input  logic              l2_accept,
   input  logic              l2_clear,
   input  logic              rd_ready,
   output logic              busy,
   output logic              done,
   output logic [CNT_W-1:0]  hit_count,
   output logic              rd_valid,
   output logic [ENT_W-1:0]  rd_data
);
   localparam int SLOTS = 1 << SLOT_W;

   if (2 * WIN_MAX + 4 > SLOTS) begin : g_bad_window
      $error("WIN_MAX too large for the history depth");
   end
   if (MAX_HITS < 2) begin : g_bad_cap
      $error("MAX_HITS must be at least 2");
   end
   if (FINE_W < 1) begin : g_bad_fine
      $error("FINE_W must be at least 1");
   end

   hwc_state_e        state_q, state_d;
   logic [SLOT_W-1:0] now_q;
   logic [SLOT_W:0]   el_q;
   logic              mem_hit, scan_active, scan_fin, scan_push, last_pop, flush;
   logic [FINE_W-1:0] mem_fine;
   logic [SLOT_W-1:0] scan_addr;
   logic [ENT_W-1:0]  scan_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         now_q <= '0;
         el_q  <= '0;
      end else begin
         now_q <= now_q + SLOT_W'(1);
         if (el_q != (SLOT_W + 1)'(SLOTS)) el_q <= el_q + (SLOT_W + 1)'(1);
      end
   end

   hwc_ring_mem #(.SLOT_W(SLOT_W), .FINE_W(FINE_W)) i_mem (
      .clk     (clk),
      .wr_hit  (hit_valid),
      .wr_fine (hit_fine),
      .wr_addr (now_q),
      .rd_addr (scan_addr),
      .rd_hit  (mem_hit),
      .rd_fine (mem_fine)
   );

   hwc_win_scan #(.SLOT_W(SLOT_W), .FINE_W(FINE_W), .WIN_MAX(WIN_MAX)) i_scan (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (state_q == ST_IDLE && trig),
      .t_now     (now_q),
      .win_req   (win_len),
      .elapsed   (el_q),
      .rd_hit    (mem_hit),
      .rd_fine   (mem_fine),
      .rd_addr   (scan_addr),
      .active    (scan_active),
      .fin       (scan_fin),
      .push      (scan_push),
      .push_data (scan_data)
   );

   hwc_chan_buf #(.ENT_W(ENT_W), .MAX_HITS(MAX_HITS)) i_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .push      (scan_push),
      .push_data (scan_data),
      .rd_en     (state_q == ST_SEND),
      .rd_ready  (rd_ready),
      .count     (hit_count),
      .rd_valid  (rd_valid),
      .rd_data   (rd_data),
      .last_pop  (last_pop)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (trig) state_d = ST_SCAN;
         ST_SCAN: if (scan_fin) state_d = ST_HOLD;
         ST_HOLD: begin
            if (l2_clear) state_d = ST_IDLE;
            else if (l2_accept) state_d = (hit_count == '0) ? ST_IDLE : ST_SEND;
         end
         ST_SEND: if (last_pop) state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   assign flush = (state_q != ST_IDLE) && (state_d == ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign busy = (state_q != ST_IDLE);
   assign done = (state_q == ST_HOLD) || (state_q == ST_SEND);

   // R7: a clear while held drops the event at once
   a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HOLD && l2_clear) |=> (!busy && hit_count == '0));
   // R5: the walk and the control state agree
   a_r5_scan_matches: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SCAN) |-> scan_active);
   // R8: commands during the walk leave it running
   a_r8_walk_undisturbed: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SCAN && !scan_fin) |=> (state_q == ST_SCAN));
endmodule

// File: tb/test_hit_window_capture.sv
module test_hit_window_capture;
   localparam int SLOT_W = 11, FINE_W = 8, MAX_HITS = 16, WIN_MAX = 1000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic hit_valid = 1'b0, trig = 1'b0, l2_accept = 1'b0, l2_clear = 1'b0, rd_ready = 1'b0;
   logic [FINE_W-1:0] hit_fine = '0;
   logic [SLOT_W-1:0] win_len = '0;
   logic busy, done, rd_valid;
   logic [4:0] hit_count;
   logic [SLOT_W+FINE_W-1:0] rd_data;

   always #5 clk = ~clk;

   hit_window_capture #(.SLOT_W(SLOT_W), .FINE_W(FINE_W), .MAX_HITS(MAX_HITS),
                        .WIN_MAX(WIN_MAX)) i_hit_window_capture (
      .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_fine(hit_fine),
      .trig(trig), .win_len(win_len), .l2_accept(l2_accept), .l2_clear(l2_clear),
      .rd_ready(rd_ready), .busy(busy), .done(done), .hit_count(hit_count),
      .rd_valid(rd_valid), .rd_data(rd_data)
   );

   int checks = 0, fails = 0, cyc = 0, hit_mode = 0;
   int mnow = 0, mst = 0, left = 0, idx = 0;
   int hist_t[$], hist_f[$], exp_q[$];

   task automatic chk(string tag, int act, int expv);
      checks++;
      if (act != expv) begin
         fails++;
         $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, expv);
      end
   endtask

   // hit generator
   always @(posedge clk) begin
      #2;
      case (hit_mode)
         1: hit_valid <= ((cyc * 7) % 5 == 0);
         2: hit_valid <= 1'b1;
         default: hit_valid <= 1'b0;
      endcase
      hit_fine <= FINE_W'((cyc * 37) ^ 8'h5A);
   end

   // behavioural reference model
   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         mnow = 0; mst = 0; idx = 0;
         hist_t.delete(); hist_f.delete(); exp_q.delete();
      end else begin
         if (hit_valid) begin hist_t.push_back(mnow); hist_f.push_back(int'(hit_fine)); end
         case (mst)
            0: if (trig) begin
               int w;
               w = (int'(win_len) > WIN_MAX) ? WIN_MAX : int'(win_len);
               exp_q.delete();
               foreach (hist_t[i])
                  if (hist_t[i] <= mnow && mnow - hist_t[i] < w && exp_q.size() < MAX_HITS)
                     exp_q.push_back(((mnow - hist_t[i]) << FINE_W) | hist_f[i]);
               left = w + 1; idx = 0; mst = 1;
            end
            1: begin left--; if (left == 0) mst = 2; end
            2: if (l2_clear) begin mst = 0; exp_q.delete(); end
               else if (l2_accept) begin
                  if (exp_q.size() == 0) mst = 0; else mst = 3;
               end
            3: if (rd_ready) begin
               idx++;
               if (idx == exp_q.size()) begin mst = 0; idx = 0; exp_q.delete(); end
            end
            default: mst = 0;
         endcase
         mnow++;
         while (hist_t.size() > 0 && mnow - hist_t[0] > 2100) begin
            void'(hist_t.pop_front()); void'(hist_f.pop_front());
         end
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R5 busy", int'(busy), int'(mst != 0));
         chk("R5 done", int'(done), int'(mst >= 2));
         chk("R6 rd_valid", int'(rd_valid), int'(mst == 3));
         if (mst == 0) chk("R7 idle count", int'(hit_count), 0);
         if (mst >= 2) chk("R2 hit_count", int'(hit_count), exp_q.size());
         if (mst == 3 && idx < exp_q.size()) chk("R3 rd_data", int'(rd_data), exp_q[idx]);
      end
   end

   always @(posedge clk) begin
      if (cyc > 150000) begin
         fails++; checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic step(); @(posedge clk); #2; endtask
   task automatic pulse_trig(int w);
      win_len = SLOT_W'(w); trig = 1'b1; step(); trig = 1'b0;
   endtask
   task automatic wait_hold(); while (mst != 2) step(); endtask
   task automatic accept(); l2_accept = 1'b1; step(); l2_accept = 1'b0; endtask
   task automatic clear(); l2_clear = 1'b1; step(); l2_clear = 1'b0; endtask
   task automatic read_all(bit stall);
      int n = 0;
      while (mst == 3) begin
         rd_ready = stall ? (n % 2 == 1) : 1'b1;
         n++;
         step();
      end
      rd_ready = 1'b0;
   endtask

   initial begin
      step(); step();
      @(negedge clk);
      chk("R1 busy", int'(busy), 0);
      chk("R1 done", int'(done), 0);
      chk("R1 rd_valid", int'(rd_valid), 0);
      chk("R1 count", int'(hit_count), 0);
      @(posedge clk); #2; rst_n = 1'b1;

      // R10: early trigger, window reaches before reset
      hit_mode = 1;
      repeat (6) step();
      pulse_trig(30);
      wait_hold();
      chk("R10 early count", int'(hit_count), exp_q.size());
      accept(); read_all(0);

      // R2/R3/R8: sparse hits, stalled readout, ignored commands
      repeat (300) step();
      pulse_trig(25);
      step();
      l2_accept = 1'b1; step(); l2_accept = 1'b0;
      @(negedge clk); chk("R8 accept in walk", int'(done), 0);
      step();
      l2_clear = 1'b1; step(); l2_clear = 1'b0;
      @(negedge clk); chk("R8 clear in walk", int'(busy), 1);
      step();
      pulse_trig(5);   // R5: ignored while busy
      wait_hold();
      accept(); read_all(1);

      // R4/R7: dense hits hit the cap, then cleared
      hit_mode = 2;
      repeat (60) step();
      pulse_trig(40);
      wait_hold();
      chk("R4 cap", int'(hit_count), MAX_HITS);
      clear();
      @(negedge clk); chk("R7 cleared", int'(busy), 0);

      // R9: hits written during the previous walk are captured
      hit_mode = 1;
      step();
      pulse_trig(45);
      wait_hold();
      chk("R9 count", int'(hit_count), exp_q.size());
      accept(); read_all(0);

      // R7: clear wins over accept
      pulse_trig(20);
      wait_hold();
      l2_accept = 1'b1; l2_clear = 1'b1; step(); l2_accept = 1'b0; l2_clear = 1'b0;
      @(negedge clk); chk("R7 clear priority", int'(busy), 0);

      // R6: empty window released directly
      pulse_trig(0);
      wait_hold();
      chk("R6 empty count", int'(hit_count), 0);
      accept();
      @(negedge clk); chk("R6 empty release", int'(busy), 0);

      // R10: window across the counter wrap
      while ((mnow % 2048) != 10) step();
      pulse_trig(60);
      wait_hold();
      chk("R10 wrap count", int'(hit_count), exp_q.size());
      accept(); read_all(0);

      // R2: window clamp to WIN_MAX
      begin
         int t0;
         step();
         t0 = cyc;
         pulse_trig(2047);
         wait_hold();
         chk("R2 clamp length", cyc - t0, WIN_MAX + 2);
         accept(); read_all(0);
      end

      repeat (5) step();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule